// File: doc/BRIEF.md
# Exception entry controller

This block carries out the entry step when a 32-bit in-order core takes an exception. The pipeline presents the context of the faulting instruction: its PC, whether it sits in a branch delay slot, whether that branch was taken, and the coprocessor number in its encoding. It also raises one of two requests. One is an ordinary exception, which comes with its own code. The other is a hardware debug breakpoint. On an accepted request the block saves the PC in the exception-PC register and merges the new cause fields into the cause register. It also pushes the interrupt-enable/mode stack in the status register and, in the next cycle, issues a one-cycle flush pulse together with the redirect address.

The redirect address is built from a base and an offset. The base depends on the boot-vector bit of the status register. The offset depends on whether the entry is a debug breakpoint. A software write port lets the surrounding core load any of the three registers directly.

The controller is a two-state machine. IDLE waits for a request. The transition IDLE→REDIRECT happens on an accepted request. REDIRECT drives the flush pulse, and the transition REDIRECT→IDLE is unconditional after one cycle. Requests that arrive while in REDIRECT belong to the squashed instruction and are dropped.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, cause_q is 0, epc_q is 0, sr_q is 0x00400000 (the boot-vector bit, bit 22, set) and redirect_valid is 0.
- R2: The redirect base is 0xBFC00100 when sr_q bit 22 is 1 at the time of the request, and 0x80000000 when it is 0.
- R3: A debug breakpoint request redirects to the base ORed with 0x40 and writes exception code 9 into cause_q[6:2]. An ordinary request redirects to the base ORed with 0x80 and writes exc_code into cause_q[6:2].
- R4: On an accepted request, epc_q is loaded with inst_pc at the same clock edge.
- R5: On an accepted request, cause_q bit 31 takes inst_bd, bit 30 takes inst_bt, bits 29:28 take inst_cop and bits 6:2 take the code. Every other bit of cause_q keeps its value.
- R6: On an accepted request, sr_q[5:0] becomes {old sr_q[3:0], 2'b00}. sr_q[31:6] are unchanged.
- R7: redirect_valid is high for exactly the one cycle after the accepting edge, with redirect_pc holding the vector in that cycle.
- R8: When dbg_req and exc_req are high together, the debug breakpoint is taken (offset 0x40, code 9).
- R9: A request presented while redirect_valid is high is ignored: no register changes from it and no second pulse follows.
- R10: A software write with sw_we high loads sw_wdata into cause_q (sw_sel 0), epc_q (sw_sel 1) or sr_q (sw_sel 2) at the clock edge. sw_sel 3 changes nothing.
- R11: When a request is accepted in the same cycle as a software write, the entry update wins and the software write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Ordinary exception request |
| exc_code | input | 5 | Code of the ordinary exception |
| dbg_req | input | 1 | Hardware debug breakpoint request |
| inst_pc | input | 32 | PC of the faulting instruction |
| inst_bd | input | 1 | Faulting instruction is in a delay slot |
| inst_bt | input | 1 | The branch before the slot was taken |
| inst_cop | input | 2 | Coprocessor number of the faulting instruction |
| sw_we | input | 1 | Software register write enable |
| sw_sel | input | 2 | Register select: 0 cause, 1 exception PC, 2 status, 3 none |
| sw_wdata | input | 32 | Software write data |
| cause_q | output | 32 | Cause register |
| epc_q | output | 32 | Exception PC register |
| sr_q | output | 32 | Status register |
| redirect_valid | output | 1 | Pipeline flush / redirect pulse |
| redirect_pc | output | 32 | Exception vector for the redirect |

## Verification
Three situations need cycle-exact placement of inputs, so the stimulus sets them up with directed steps around the randomised traffic. The first is a request that lands in the REDIRECT cycle and must be dropped. The second is a request that collides with a software write. The third is a debug request that coincides with an ordinary one. The random phase rewrites the status register through the software port at random, so the stack shift and both vector bases are exercised against each other. Any bits that the random phase places outside the cause write mask must survive every entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN     = 32;
    localparam int CODE_W   = 5;
    localparam int COP_W    = 2;
    localparam int STACK_W  = 6;

    // cause field positions (decoded by the handler software)
    localparam int CAUSE_BD_BIT  = 31;
    localparam int CAUSE_BT_BIT  = 30;
    localparam int CAUSE_COP_LO  = 28;
    localparam int CAUSE_CODE_LO = 2;
    localparam logic [XLEN-1:0] CAUSE_ENTRY_MASK = 32'hF000_007C;

    localparam int SR_BOOT_BIT = 22;
    localparam logic [XLEN-1:0] SR_RESET = 32'h0040_0000;

    localparam logic [CODE_W-1:0] CODE_BREAK = 5'd9;

    typedef enum logic [1:0] {
        SEL_CAUSE = 2'd0,
        SEL_EPC   = 2'd1,
        SEL_SR    = 2'd2,
        SEL_NONE  = 2'd3
    } csr_sel_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_REDIRECT = 1'b1
    } entry_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
(
    input  logic              busy,
    input  logic              exc_req,
    input  logic              dbg_req,
    input  logic [CODE_W-1:0] exc_code,
    output logic              accept,
    output logic              take_dbg,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        accept   = !busy && (exc_req || dbg_req);
        take_dbg = dbg_req;
        code     = dbg_req ? CODE_BREAK : exc_code;
    end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
    parameter int              AW        = 32,
    parameter logic [AW-1:0]   BASE_BOOT = 32'hBFC0_0100,
    parameter logic [AW-1:0]   BASE_RUN  = 32'h8000_0000,
    parameter logic [AW-1:0]   OFS_DBG   = 32'h0000_0040,
    parameter logic [AW-1:0]   OFS_STD   = 32'h0000_0080
) (
    input  logic          boot_sel,
    input  logic          dbg,
    output logic [AW-1:0] vector
);
    logic [AW-1:0] base;
    always_comb begin
        base   = boot_sel ? BASE_BOOT : BASE_RUN;
        vector = base | (dbg ? OFS_DBG : OFS_STD);
    end
endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic [CODE_W-1:0] code,
    input  logic              bd,
    input  logic              bt,
    input  logic [COP_W-1:0]  cop,
    input  logic [XLEN-1:0]   pc,
    input  logic              sw_we,
    input  csr_sel_e          sw_sel,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   cause,
    output logic [XLEN-1:0]   epc,
    output logic [XLEN-1:0]   sr
);
    logic [XLEN-1:0] cause_ins;
    logic [XLEN-1:0] sr_pushed;

    always_comb begin
        cause_ins = '0;
        cause_ins[CAUSE_BD_BIT]                       = bd;
        cause_ins[CAUSE_BT_BIT]                       = bt;
        cause_ins[CAUSE_COP_LO +: COP_W]              = cop;
        cause_ins[CAUSE_CODE_LO +: CODE_W]            = code;
        sr_pushed = sr;
        sr_pushed[STACK_W-1:0] = {sr[STACK_W-3:0], 2'b00};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
            epc   <= '0;
            sr    <= SR_RESET;
        end else if (enter) begin
            cause <= (cause & ~CAUSE_ENTRY_MASK) | (cause_ins & CAUSE_ENTRY_MASK);
            epc   <= pc;
            sr    <= sr_pushed;
        end else if (sw_we) begin
            unique case (sw_sel)
                SEL_CAUSE: cause <= sw_wdata;
                SEL_EPC:   epc   <= sw_wdata;
                SEL_SR:    sr    <= sw_wdata;
                SEL_NONE:  ;
            endcase
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              dbg_req,
    input  logic [XLEN-1:0]   inst_pc,
    input  logic              inst_bd,
    input  logic              inst_bt,
    input  logic [COP_W-1:0]  inst_cop,
    input  logic              sw_we,
    input  logic [1:0]        sw_sel,
    input  logic [XLEN-1:0]   sw_wdata,
    output logic [XLEN-1:0]   cause_q,
    output logic [XLEN-1:0]   epc_q,
    output logic [XLEN-1:0]   sr_q,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc
);
    entry_state_e     state, state_nx;
    logic             busy, accept, take_dbg;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]  vector;

    exc_arbiter u_arb (
        .busy(busy), .exc_req(exc_req), .dbg_req(dbg_req), .exc_code(exc_code),
        .accept(accept), .take_dbg(take_dbg), .code(code)
    );

    exc_vector_gen #(.AW(XLEN)) u_vec (
        .boot_sel(sr_q[SR_BOOT_BIT]), .dbg(take_dbg), .vector(vector)
    );

    exc_csr_file u_csr (
        .clk(clk), .rst_n(rst_n), .enter(accept), .code(code),
        .bd(inst_bd), .bt(inst_bt), .cop(inst_cop), .pc(inst_pc),
        .sw_we(sw_we), .sw_sel(csr_sel_e'(sw_sel)), .sw_wdata(sw_wdata),
        .cause(cause_q), .epc(epc_q), .sr(sr_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = ST_REDIRECT;
            ST_REDIRECT: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy           = 1'b0;
        redirect_valid = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_REDIRECT: begin
                busy           = 1'b1;
                redirect_valid = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      redirect_pc <= '0;
        else if (accept) redirect_pc <= vector;
    end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic            dbg_req,
    input logic [XLEN-1:0] inst_pc,
    input logic [XLEN-1:0] cause_q,
    input logic [XLEN-1:0] epc_q,
    input logic [XLEN-1:0] sr_q,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc
);
    logic [XLEN-1:0] base_now;
    assign base_now = sr_q[SR_BOOT_BIT] ? 32'hBFC0_0100 : 32'h8000_0000;

    // R7
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);

    // R4
    epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && (exc_req || dbg_req)) |=> (redirect_valid && epc_q == $past(inst_pc)));

    // R2
    vector_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ((redirect_pc == (base_now | 32'h40)) || (redirect_pc == (base_now | 32'h80))));

    // R8
    dbg_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && dbg_req) |=> (cause_q[6:2] == 5'd9 && redirect_pc[7:0] == 8'h40));

    // R6
    stack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && (exc_req || dbg_req)) |=> (sr_q[5:0] == {$past(sr_q[3:0]), 2'b00}));

    // R5
    cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && (exc_req || dbg_req)) |=> ((cause_q & ~CAUSE_ENTRY_MASK) == ($past(cause_q) & ~CAUSE_ENTRY_MASK)));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .dbg_req(dbg_req), .inst_pc(inst_pc),
    .cause_q(cause_q), .epc_q(epc_q), .sr_q(sr_q),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_req, dbg_req, inst_bd, inst_bt, sw_we;
    logic [4:0]  exc_code;
    logic [31:0] inst_pc, sw_wdata;
    logic [1:0]  inst_cop, sw_sel;
    logic [31:0] cause_q, epc_q, sr_q, redirect_pc;
    logic        redirect_valid;

    always #5 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code), .dbg_req(dbg_req),
        .inst_pc(inst_pc), .inst_bd(inst_bd), .inst_bt(inst_bt), .inst_cop(inst_cop),
        .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .cause_q(cause_q), .epc_q(epc_q), .sr_q(sr_q),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_cause, m_epc, m_sr, m_rpc;
    logic        m_busy;

    function automatic logic [31:0] f_vector(input logic [31:0] sr, input logic dbg);
        logic [31:0] b;
        b = sr[22] ? 32'hBFC0_0100 : 32'h8000_0000;
        return b | (dbg ? 32'h40 : 32'h80);
    endfunction

    function automatic logic [31:0] f_cause(input logic [31:0] old, input logic [4:0] code,
                                            input logic bd, input logic bt, input logic [1:0] cop);
        logic [31:0] v;
        v = old & 32'h0FFF_FF83;
        v[31] = bd; v[30] = bt; v[29:28] = cop; v[6:2] = code;
        return v;
    endfunction

    function automatic logic [31:0] f_sr(input logic [31:0] old);
        return {old[31:6], old[3:0], 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // one cycle: inputs driven at negedge, outputs compared at the next negedge
    task automatic cyc(input logic e, input logic d, input logic [4:0] code,
                       input logic bd, input logic bt, input logic [1:0] cop, input logic [31:0] pc,
                       input logic we, input logic [1:0] sel, input logic [31:0] wd);
        logic acc;
        exc_req = e; dbg_req = d; exc_code = code; inst_bd = bd; inst_bt = bt;
        inst_cop = cop; inst_pc = pc; sw_we = we; sw_sel = sel; sw_wdata = wd;
        acc = !m_busy && (e || d);
        if (acc) begin
            m_rpc   = f_vector(m_sr, d);
            m_cause = f_cause(m_cause, d ? 5'd9 : code, bd, bt, cop);
            m_epc   = pc;
            m_sr    = f_sr(m_sr);
        end else if (we) begin
            case (sel)
                2'd0: m_cause = wd;
                2'd1: m_epc   = wd;
                2'd2: m_sr    = wd;
                default: ;
            endcase
        end
        m_busy = acc;
        @(posedge clk);
        @(negedge clk);
        exc_req = 0; dbg_req = 0; sw_we = 0;
        chk("R7 redirect_valid", {31'b0, redirect_valid}, {31'b0, m_busy});
        if (m_busy) chk("R2 redirect_pc", redirect_pc, m_rpc);
        chk("R4 epc_q", epc_q, m_epc);
        chk("R5 cause_q", cause_q, m_cause);
        chk("R6 sr_q", sr_q, m_sr);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        rst_n = 0; exc_req = 0; dbg_req = 0; sw_we = 0; exc_code = 0; inst_pc = 0;
        inst_bd = 0; inst_bt = 0; inst_cop = 0; sw_sel = 0; sw_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_cause = 0; m_epc = 0; m_sr = 32'h0040_0000; m_busy = 0; m_rpc = 0;
        // R1
        chk("R1 cause_q", cause_q, 0);
        chk("R1 epc_q", epc_q, 0);
        chk("R1 sr_q", sr_q, 32'h0040_0000);
        chk("R1 redirect_valid", {31'b0, redirect_valid}, 0);

        // R3 ordinary entry with boot base
        cyc(1, 0, 5'd4, 1, 1, 2'd2, 32'h0000_1234, 0, 0, 0);
        chk("R3 std vector", redirect_pc, 32'hBFC0_0180);
        chk("R3 std code", {27'b0, cause_q[6:2]}, 4);
        idle();
        // R10 software writes on each register, then sel 3
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 32'h0000_002D);
        chk("R10 sr write", sr_q, 32'h0000_002D);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 32'h0000_AA00);
        chk("R10 cause write", cause_q, 32'h0000_AA00);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 32'h0BAD_F00C);
        chk("R10 epc write", epc_q, 32'h0BAD_F00C);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        chk("R10 sel3 no effect", sr_q, 32'h0000_002D);
        // R3 debug breakpoint with run base; cause Ip bits kept
        cyc(0, 1, 5'd1, 0, 0, 2'd0, 32'h8001_0000, 0, 0, 0);
        chk("R3 dbg vector", redirect_pc, 32'h8000_0040);
        chk("R3 dbg code", {27'b0, cause_q[6:2]}, 9);
        chk("R6 stack push", {26'b0, sr_q[5:0]}, 32'h34);
        // R9 request in redirect cycle is dropped
        cyc(1, 0, 5'd8, 1, 0, 2'd1, 32'h0000_0999, 0, 0, 0);
        chk("R9 no pulse", {31'b0, redirect_valid}, 0);
        chk("R9 epc kept", epc_q, 32'h8001_0000);
        // R8 simultaneous requests
        cyc(1, 1, 5'd12, 0, 1, 2'd3, 32'h0000_4000, 0, 0, 0);
        chk("R8 dbg wins vector", redirect_pc, 32'h8000_0040);
        chk("R8 dbg wins code", {27'b0, cause_q[6:2]}, 9);
        idle();
        // R11 raise wins over software write
        cyc(1, 0, 5'd10, 0, 0, 2'd0, 32'h0000_5000, 1, 2'd1, 32'hDEAD_BEEF);
        chk("R11 epc from entry", epc_q, 32'h0000_5000);
        idle();

        for (int i = 0; i < 400; i++) begin
            logic e, d, w;
            e = ($urandom % 4) == 0;
            d = ($urandom % 8) == 0;
            w = ($urandom % 4) == 0;
            cyc(e, d, 5'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), $urandom,
                w, 2'($urandom), $urandom);
        end
        summary();
    end
endmodule